// File: doc/BRIEF.md
# Asynchronous SRAM Write Strobe Sequencer

This block sits between a synchronous host and a 64K x 8 asynchronous static RAM and turns a single-cycle write request into a complete, timed write cycle on the memory pins. The host offers a 16-bit address and an 8-bit data byte together with a request strobe. The block takes them when it signals ready, and then drives the two chip selects, the write strobe, the output enable, the address bus and the data bus with its drive enable. Each phase lasts long enough to meet its own minimum.

Each phase length is a whole number of system clocks. The lengths are worked out at elaboration from the clock period and a speed-grade parameter. Each nanosecond minimum is rounded up to whole clocks, and no phase is shorter than one clock. A second parameter keeps the output enable low through the write instead of high. In that mode the data driver waits out the memory's turn-off time before it drives, and the strobe is lengthened so that no bus contention can occur.

Top module: `sram_wr_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, req_ready is 1, sram_cs_n is 1, sram_cs is 0, sram_we_n is 1 and sram_dq_oe is 0.
- R2: A request is taken at a rising edge where req_valid and req_ready are both 1. req_ready is then 0 for exactly TOTAL cycles, where TOTAL = PULSE + 2 + RECOV, and then returns to 1.
- R3: A req_valid seen while req_ready is 0 has no effect: the address and data on the memory pins, and the timing of the current cycle, stay unchanged.
- R4: sram_addr and sram_dq_out take the accepted request's address and data at the accepting edge. They stay stable for as long as the selects are asserted.
- R5: Both selects (sram_cs_n = 0, sram_cs = 1) are asserted for one clock before sram_we_n falls and remain asserted for one clock after sram_we_n rises. A write therefore starts on the strobe's fall and ends on its rise.
- R6: sram_we_n is low for exactly PULSE consecutive cycles. PULSE = max(ceil(WP), DON + ceil(DW), ceil(AW) - 1) and, in held-low mode, also at least ceil(WHZ + DW).
- R7: sram_dq_oe rises DON cycles after sram_we_n falls and falls one cycle after sram_we_n rises. DON is 1 in the default mode and ceil(WHZ) in held-low mode.
- R8: sram_oe_n is constantly 1 when OE_HELD_LOW = 0 and constantly 0 when OE_HELD_LOW = 1.
- R9: If ceil(WC) exceeds PULSE + 2, a recovery period of RECOV = ceil(WC) - PULSE - 2 idle cycles, with the selects released, pads the cycle. Otherwise RECOV is 0.
- R10: The nanosecond minimums for grades 0/1/2 are WC 55/70/85, WP 40/50/55, AW 50/60/75, DW 30/30/35 and WHZ 20/25/30. ceil(x) means ceiling division by CLK_PERIOD_NS, with a floor of one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Write request strobe |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_ready | output | 1 | High when a request can be taken |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_cs | output | 1 | Chip select, active high |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_addr | output | ADDR_W | Address to the memory |
| sram_dq_out | output | DATA_W | Data to the memory |
| sram_dq_oe | output | 1 | Data bus drive enable |

## Verification
The bench drives three instances with the same stimulus. The first uses a 10 ns clock, grade 0 and default mode, giving a 4-clock strobe with the driver on after one clock. The second uses a 10 ns clock, grade 2 and held-low mode, giving a 7-clock strobe with the driver delayed three clocks. The third uses a 3 ns clock, grade 2 and default mode. In the third, the address-to-end rule sets a 24-clock strobe and the cycle-time minimum adds three recovery clocks, which is the only setting of the three where the recovery phase is reached. Requests arrive singly, during a busy cycle, at the address extremes, and held high so that cycles run back to back.

// File: rtl/sram_wr_pkg.sv
// Package: shared phase type and elaboration-time timing arithmetic for the
// SRAM write sequencer. Assumes all times are whole nanoseconds.
package sram_wr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ADDR  = 3'd1,
        PH_PULSE = 3'd2,
        PH_HOLD  = 3'd3,
        PH_RECOV = 3'd4
    } phase_t;

    localparam int T_CYCLE = 0;
    localparam int T_STROBE = 1;
    localparam int T_ADDR_END = 2;
    localparam int T_DATA_SET = 3;
    localparam int T_TURNOFF = 4;

    // Nanosecond minimum of one timing item for a speed grade (R10).
    function automatic int grade_ns(int grade, int item);
        int g;
        g = (grade < 0) ? 0 : ((grade > 2) ? 2 : grade);
        case (item)
            T_CYCLE:    return (g == 0) ? 55 : ((g == 1) ? 70 : 85);
            T_STROBE:   return (g == 0) ? 40 : ((g == 1) ? 50 : 55);
            T_ADDR_END: return (g == 0) ? 50 : ((g == 1) ? 60 : 75);
            T_DATA_SET: return (g == 2) ? 35 : 30;
            default:    return (g == 0) ? 20 : ((g == 1) ? 25 : 30);
        endcase
    endfunction

    // Round a nanosecond figure up to clocks, never below one clock.
    function automatic int ns_to_clk(int ns, int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wr_fsm.sv
// Module: phase sequencer. Steps IDLE -> ADDR -> PULSE x PULSE_CLKS -> HOLD
// -> RECOV x RECOV_CLKS -> IDLE and publishes the next phase and count so the
// pad stage can register its outputs. Assumes PULSE_CLKS >= 1.
module sram_wr_fsm
    import sram_wr_pkg::*;
#(
    parameter int PULSE_CLKS = 4,
    parameter int RECOV_CLKS = 0,
    parameter int CNT_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             ready,
    output logic             accept,
    output phase_t           nxt_phase,
    output logic [CNT_W-1:0] nxt_cnt
);

    localparam int TOTAL_CLKS = PULSE_CLKS + 2 + RECOV_CLKS;
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CLKS - 1);
    localparam logic [CNT_W-1:0] RECOV_LAST =
        (RECOV_CLKS > 0) ? CNT_W'(RECOV_CLKS - 1) : '0;

    phase_t           phase;
    logic [CNT_W-1:0] cnt;

    assign ready  = (phase == PH_IDLE);
    assign accept = ready && req_valid;

    // Next-phase and next-count decision.
    always_comb begin
        nxt_phase = phase;
        nxt_cnt   = cnt;
        case (phase)
            PH_IDLE: begin
                if (req_valid) begin
                    nxt_phase = PH_ADDR;
                    nxt_cnt   = '0;
                end
            end
            PH_ADDR: begin
                nxt_phase = PH_PULSE;
                nxt_cnt   = '0;
            end
            PH_PULSE: begin
                if (cnt == PULSE_LAST) begin
                    nxt_phase = PH_HOLD;
                    nxt_cnt   = '0;
                end else begin
                    nxt_cnt = cnt + 1'b1;
                end
            end
            PH_HOLD: begin
                nxt_cnt   = '0;
                nxt_phase = (RECOV_CLKS > 0) ? PH_RECOV : PH_IDLE;
            end
            PH_RECOV: begin
                if (cnt == RECOV_LAST) begin
                    nxt_phase = PH_IDLE;
                    nxt_cnt   = '0;
                end else begin
                    nxt_cnt = cnt + 1'b1;
                end
            end
            default: begin
                nxt_phase = PH_IDLE;
                nxt_cnt   = '0;
            end
        endcase
    end

    // Phase and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            phase <= nxt_phase;
            cnt   <= nxt_cnt;
        end
    end

    // Length of the current busy stretch, for the busy-window check.
    int busy_len;
    always_ff @(posedge clk) begin
        if (!rst_n || ready) busy_len <= 0;
        else                 busy_len <= busy_len + 1;
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> !ready); // R2
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (busy_len == TOTAL_CLKS)); // R2
    AST_BUSY_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (busy_len >= 1)); // R9

endmodule

// File: rtl/sram_wr_pads.sv
// Module: pad register stage. Registers every memory-side output from the
// sequencer's next phase so the pins change only on clock edges, and latches
// address and data on acceptance. Assumes DON_CLKS < PULSE_CLKS.
module sram_wr_pads
    import sram_wr_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 3,
    parameter int DON_CLKS    = 1,
    parameter int PULSE_CLKS  = 4,
    parameter bit OE_HELD_LOW = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  phase_t            nxt_phase,
    input  logic [CNT_W-1:0]  nxt_cnt,
    output logic              sram_cs_n,
    output logic              sram_cs,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe
);

    localparam logic [CNT_W-1:0] DON_CNT = CNT_W'(DON_CLKS);

    logic sel_nxt;
    logic we_nxt;
    logic drv_nxt;

    // Decode the pin levels that belong to the coming phase.
    always_comb begin
        sel_nxt = (nxt_phase == PH_ADDR) || (nxt_phase == PH_PULSE) ||
                  (nxt_phase == PH_HOLD);
        we_nxt  = (nxt_phase == PH_PULSE);
        drv_nxt = ((nxt_phase == PH_PULSE) && (nxt_cnt >= DON_CNT)) ||
                  (nxt_phase == PH_HOLD);
    end

    // Control pin registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_cs_n  <= 1'b1;
            sram_cs    <= 1'b0;
            sram_we_n  <= 1'b1;
            sram_dq_oe <= 1'b0;
        end else begin
            sram_cs_n  <= !sel_nxt;
            sram_cs    <= sel_nxt;
            sram_we_n  <= !we_nxt;
            sram_dq_oe <= drv_nxt;
        end
    end

    // Address and data capture on acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_addr   <= '0;
            sram_dq_out <= '0;
        end else if (accept) begin
            sram_addr   <= req_addr;
            sram_dq_out <= req_data;
        end
    end

    // Output enable level is fixed by the mode.
    generate
        if (OE_HELD_LOW) begin : g_oe_low
            assign sram_oe_n = 1'b0;
        end else begin : g_oe_high
            assign sram_oe_n = 1'b1;
        end
    endgenerate

    // Strobe-low run length, for the pulse-width check.
    int low_len;
    always_ff @(posedge clk) begin
        if (!rst_n || sram_we_n) low_len <= 0;
        else                     low_len <= low_len + 1;
    end

    AST_WE_INSIDE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_cs_n && sram_cs)); // R5
    AST_SEL_BEFORE_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> $past(!sram_cs_n && sram_cs)); // R5
    AST_SEL_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (!sram_cs_n && sram_cs)); // R5
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (low_len == PULSE_CLKS)); // R6
    AST_DRV_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> !sram_dq_oe); // R7
    AST_DRV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> sram_dq_oe); // R7
    AST_DRV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_dq_oe) |-> (sram_we_n && $past(sram_we_n))); // R7
    AST_PINS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && $past(!sram_cs_n)) |->
        ($stable(sram_addr) && $stable(sram_dq_out))); // R4

endmodule

// File: rtl/sram_wr_seq.sv
// Module: top of the asynchronous SRAM write sequencer. Derives every phase
// length in clocks from CLK_PERIOD_NS and SPEED_GRADE, then ties the phase
// sequencer to the pad register stage. Assumes one write in flight at a time.
module sram_wr_seq
    import sram_wr_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int SPEED_GRADE   = 0,
    parameter bit OE_HELD_LOW   = 1'b0,
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    output logic              sram_cs_n,
    output logic              sram_cs,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe
);

    localparam int NS_WC  = grade_ns(SPEED_GRADE, T_CYCLE);
    localparam int NS_WP  = grade_ns(SPEED_GRADE, T_STROBE);
    localparam int NS_AW  = grade_ns(SPEED_GRADE, T_ADDR_END);
    localparam int NS_DW  = grade_ns(SPEED_GRADE, T_DATA_SET);
    localparam int NS_WHZ = grade_ns(SPEED_GRADE, T_TURNOFF);

    localparam int C_WC     = ns_to_clk(NS_WC, CLK_PERIOD_NS);
    localparam int C_WP     = ns_to_clk(NS_WP, CLK_PERIOD_NS);
    localparam int C_AW     = ns_to_clk(NS_AW, CLK_PERIOD_NS);
    localparam int C_DW     = ns_to_clk(NS_DW, CLK_PERIOD_NS);
    localparam int C_WHZ    = ns_to_clk(NS_WHZ, CLK_PERIOD_NS);
    localparam int C_WHZ_DW = ns_to_clk(NS_WHZ + NS_DW, CLK_PERIOD_NS);

    localparam int DON_CLKS   = OE_HELD_LOW ? C_WHZ : 1;
    localparam int PULSE_BASE = imax(imax(C_WP, DON_CLKS + C_DW), C_AW - 1);
    localparam int PULSE_CLKS = OE_HELD_LOW ? imax(PULSE_BASE, C_WHZ_DW) : PULSE_BASE;
    localparam int RECOV_CLKS = imax(0, C_WC - PULSE_CLKS - 2);
    localparam int CNT_W      = $clog2(imax(PULSE_CLKS, RECOV_CLKS) + 1);

    logic             accept;
    phase_t           nxt_phase;
    logic [CNT_W-1:0] nxt_cnt;

    sram_wr_fsm #(
        .PULSE_CLKS (PULSE_CLKS),
        .RECOV_CLKS (RECOV_CLKS),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .ready     (req_ready),
        .accept    (accept),
        .nxt_phase (nxt_phase),
        .nxt_cnt   (nxt_cnt)
    );

    sram_wr_pads #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .CNT_W       (CNT_W),
        .DON_CLKS    (DON_CLKS),
        .PULSE_CLKS  (PULSE_CLKS),
        .OE_HELD_LOW (OE_HELD_LOW)
    ) u_pads (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .req_addr    (req_addr),
        .req_data    (req_data),
        .nxt_phase   (nxt_phase),
        .nxt_cnt     (nxt_cnt),
        .sram_cs_n   (sram_cs_n),
        .sram_cs     (sram_cs),
        .sram_we_n   (sram_we_n),
        .sram_oe_n   (sram_oe_n),
        .sram_addr   (sram_addr),
        .sram_dq_out (sram_dq_out),
        .sram_dq_oe  (sram_dq_oe)
    );

    // Elaboration-time sanity of the derived counts (R6, R10).
    initial begin
        AST_PULSE_COVERS_DATA: assert (PULSE_CLKS > DON_CLKS) // R6
            else $error("strobe shorter than driver delay");
        AST_COUNTS_POSITIVE: assert (C_WC >= 1 && C_WP >= 1) // R10
            else $error("clock count below one");
    end

endmodule

// File: tb/sram_wr_seq_tb.sv
// Bench: three instances, a behavioural position-counter model per instance,
// compared on every falling clock edge.
module sram_wr_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N = 3;
    localparam int WATCHDOG = 5000;

    // Expected timing per instance, from the requirement formulas:
    // 0: 10ns g0 default : WC6 WP4 AW5 DW3 -> DON1 PULSE max(4,4,4)=4, RECOV 0, TOTAL 6
    // 1: 10ns g2 held-low: WC9 WP6 AW8 DW4 WHZ3 WHZ+DW 7 -> DON3 PULSE 7, RECOV 0, TOTAL 9
    // 2:  3ns g2 default : WC29 WP19 AW25 DW12 -> DON1 PULSE 24, RECOV 3, TOTAL 29
    int exp_pulse [N] = '{4, 7, 24};
    int exp_don   [N] = '{1, 3, 1};
    int exp_total [N] = '{6, 9, 29};
    bit exp_oel   [N] = '{1'b0, 1'b1, 1'b0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_data = '0;

    logic        rdy   [N];
    logic        cs_n  [N];
    logic        cs    [N];
    logic        we_n  [N];
    logic        oe_n  [N];
    logic [15:0] addr  [N];
    logic [7:0]  dq    [N];
    logic        dq_oe [N];

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_wr_seq #(.CLK_PERIOD_NS(10), .SPEED_GRADE(0), .OE_HELD_LOW(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_ready(rdy[0]), .sram_cs_n(cs_n[0]), .sram_cs(cs[0]),
        .sram_we_n(we_n[0]), .sram_oe_n(oe_n[0]), .sram_addr(addr[0]),
        .sram_dq_out(dq[0]), .sram_dq_oe(dq_oe[0]));

    sram_wr_seq #(.CLK_PERIOD_NS(10), .SPEED_GRADE(2), .OE_HELD_LOW(1'b1)) u_dut_low (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_ready(rdy[1]), .sram_cs_n(cs_n[1]), .sram_cs(cs[1]),
        .sram_we_n(we_n[1]), .sram_oe_n(oe_n[1]), .sram_addr(addr[1]),
        .sram_dq_out(dq[1]), .sram_dq_oe(dq_oe[1]));

    sram_wr_seq #(.CLK_PERIOD_NS(3), .SPEED_GRADE(2), .OE_HELD_LOW(1'b0)) u_dut_fast (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_ready(rdy[2]), .sram_cs_n(cs_n[2]), .sram_cs(cs[2]),
        .sram_we_n(we_n[2]), .sram_oe_n(oe_n[2]), .sram_addr(addr[2]),
        .sram_dq_out(dq[2]), .sram_dq_oe(dq_oe[2]));

    // Reference model: position within the write cycle, 0 when idle.
    int          pos [N];
    logic [15:0] m_addr [N];
    logic [7:0]  m_data [N];

    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                pos[i] <= 0;
            end else if (pos[i] == 0) begin
                if (req_valid) begin
                    pos[i]    <= 1;
                    m_addr[i] <= req_addr;
                    m_data[i] <= req_data;
                end
            end else begin
                pos[i] <= (pos[i] == exp_total[i]) ? 0 : pos[i] + 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int inst,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s inst%0d cycle %0d: actual %0h expected %0h",
                     tag, inst, cycles, act, exp);
        end
    endtask

    // Compare every instance against the model on the falling edge.
    always @(negedge clk) begin
        cycles++;
        for (int i = 0; i < N; i++) begin
            int  p;
            bit  e_sel, e_we, e_drv;
            p     = pos[i];
            e_sel = (p >= 1) && (p <= exp_pulse[i] + 2);
            e_we  = (p >= 2) && (p <= exp_pulse[i] + 1);
            e_drv = (p >= 2 + exp_don[i]) && (p <= exp_pulse[i] + 2);
            if (!rst_n) begin
                check(rdy[i] == 1'b1 && cs_n[i] == 1'b1 && cs[i] == 1'b0 &&
                      we_n[i] == 1'b1 && dq_oe[i] == 1'b0, "R1 reset pins", i,
                      {rdy[i], cs_n[i], cs[i], we_n[i], dq_oe[i]}, 5'b11010);
            end else begin
                check(rdy[i] == (p == 0), "R2 R9 ready window", i, rdy[i], p == 0);
                check(cs_n[i] == !e_sel && cs[i] == e_sel, "R5 selects", i,
                      {cs_n[i], cs[i]}, {!e_sel, e_sel});
                check(we_n[i] == !e_we, "R6 R10 strobe", i, we_n[i], !e_we);
                check(dq_oe[i] == e_drv, "R7 driver", i, dq_oe[i], e_drv);
                check(oe_n[i] == !exp_oel[i], "R8 output enable", i, oe_n[i], !exp_oel[i]);
                if (e_sel) begin
                    check(addr[i] == m_addr[i], "R4 R3 address", i, addr[i], m_addr[i]);
                    check(dq[i] == m_data[i], "R4 R3 data", i, dq[i], m_data[i]);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_data  = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired after %0d cycles", WATCHDOG);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        idle(3);
        // R4 address extreme high, data all zero
        pulse_req(16'hFFFF, 8'h00);
        idle(40);
        // R4 address zero, data all ones; R3 second request lands while busy
        pulse_req(16'h0000, 8'hFF);
        idle(2);
        pulse_req(16'h1234, 8'h5A);
        idle(40);
        // R2 held request: back-to-back cycles with changing address
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_addr  = 16'(16'hA000 + k * 3);
            req_data  = 8'(k * 7);
        end
        @(negedge clk);
        req_valid = 1'b0;
        idle(40);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule